// File: doc/BRIEF.md
# Forced Level Interrupt Request Bank

This block holds seven software-forced interrupt requests, one for each priority level of a seven-level interrupt controller. Software changes one request at a time by writing a small index, not a mask. One write-only byte register asserts the chosen request and a second write-only byte register deasserts it. An interrupt handler can therefore drop its own forced request in a single store, with no read-modify-write. A third byte register reads back all seven requests. The block presents the per-level request vector and the number of the highest forced level to the prioritisation logic around it.

The bus side is a byte-wide register port. It has an address, a write strobe, a read strobe, write data, combinational read data and an error flag. A read of either write-only register is answered with the error flag instead of data. A two-port test hook can drive a set index and a clear index into the bank in the same cycle.

The block has no sequential state machine. Each bus cycle is classified combinationally into one access class:

- ACC_IDLE: no strobe is active.
- ACC_SET: a write to the set register.
- ACC_CLR: a write to the clear register.
- ACC_READ_FRC: a read of the readback register.
- ACC_READ_BAD: a read of a write-only register.
- ACC_OTHER: any other access, which is ignored.

The only stored state is the seven-bit request bank. From its current value it moves to (current & ~clear) | set at the next edge.

Top module: `fic_force_ctl`

## Requirements
- R1: After reset, every request bit is 0, `top_lvl` is 0 and a readback at offset 0x1B returns 0x00.
- R2: A write to offset 0x1E whose low six data bits equal 0x20+k (k from 0 to 6) asserts the request of level 7-k at the next rising clock edge. Request vector bit L-1 stands for level L.
- R3: A write to offset 0x1F with the same index coding deasserts the request of level 7-k at the next rising edge.
- R4: A set or clear write whose low six data bits lie outside 0x20..0x26 leaves every request bit unchanged.
- R5: Data bits 7 and 6 are ignored. For example, 0xE3 acts exactly as 0x23.
- R6: A read at offset 0x1E or 0x1F raises `err` in the same cycle as `rd_en` and returns 0x00. Every other read leaves `err` at 0.
- R7: A read at offset 0x1B returns the requests with byte bit j showing level 7-j, so bit 6 is level 1 and bit 0 is level 7. Bit 7 reads 0. Reads at all other offsets return 0x00.
- R8: `top_lvl` equals the largest level whose request is asserted, or 0 when none is asserted.
- R9: A set or clear write changes at most the one selected bit. Every other request keeps its value, and reads never change any request.
- R10: When the test hook sets and clears the same level in the same cycle, the set wins. Hook set and hook clear also act alone with the same index coding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 8 | Byte offset from the controller base |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data, valid in the cycle of `rd_en` |
| err | output | 1 | Error response to a read of a write-only register |
| tst_set_en | input | 1 | Test hook: set enable |
| tst_set_idx | input | 6 | Test hook: set index |
| tst_clr_en | input | 1 | Test hook: clear enable |
| tst_clr_idx | input | 6 | Test hook: clear index |
| frc_req | output | 7 | Forced requests, bit L-1 is level L |
| top_lvl | output | 3 | Highest forced level, 0 if none |

## Verification
Two functions can act in the same cycle: a set and a clear landing on the bank. On the single bus this cannot happen, so the bench provokes it through the test hook. For every level it drives equal set and clear indices in one cycle and expects the bit to end up set. It also drives set and clear at different levels in one cycle and expects both to take effect. Around this, the bench sweeps every data byte through both write registers from varied preloaded states and every address through the read path. It compares the request vector, the readback byte and the highest level against a model computed arithmetically.

// File: rtl/fic_pkg.sv
package fic_pkg;

    // classification of one bus cycle
    typedef enum logic [2:0] {
        ACC_IDLE,
        ACC_SET,
        ACC_CLR,
        ACC_READ_FRC,
        ACC_READ_BAD,
        ACC_OTHER
    } acc_e;

endpackage

// File: rtl/fic_bus_dec.sv
module fic_bus_dec
    import fic_pkg::*;
#(
    parameter int AW      = 8,
    parameter int OFS_FRC = 8'h1B,
    parameter int OFS_SET = 8'h1E,
    parameter int OFS_CLR = 8'h1F
) (
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic          rd_en,
    output acc_e          acc
);

    localparam logic [AW-1:0] A_FRC = AW'(OFS_FRC);
    localparam logic [AW-1:0] A_SET = AW'(OFS_SET);
    localparam logic [AW-1:0] A_CLR = AW'(OFS_CLR);

    always_comb begin
        acc = ACC_IDLE;
        if (wr_en) begin
            if (addr == A_SET)      acc = ACC_SET;
            else if (addr == A_CLR) acc = ACC_CLR;
            else                    acc = ACC_OTHER;
        end else if (rd_en) begin
            if (addr == A_FRC)                        acc = ACC_READ_FRC;
            else if (addr == A_SET || addr == A_CLR)  acc = ACC_READ_BAD;
            else                                      acc = ACC_OTHER;
        end
    end

endmodule

// File: rtl/fic_idx_dec.sv
module fic_idx_dec #(
    parameter int LVL_N    = 7,
    parameter int IDX_W    = 6,
    parameter int IDX_BASE = 32
) (
    input  logic             en,
    input  logic [IDX_W-1:0] idx,
    output logic [LVL_N-1:0] lvl_mask
);

    // index IDX_BASE+k selects level LVL_N-k, i.e. mask bit LVL_N-1-k
    for (genvar k = 0; k < LVL_N; k++) begin : g_slot
        assign lvl_mask[LVL_N-1-k] = en && (idx == IDX_W'(IDX_BASE + k));
    end

endmodule

// File: rtl/fic_force_bank.sv
module fic_force_bank #(
    parameter int LVL_N = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_N-1:0] set_m,
    input  logic [LVL_N-1:0] clr_m,
    output logic [LVL_N-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= (q & ~clr_m) | set_m;
    end

    // R4
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_m == '0 && clr_m == '0) |=> $stable(q));

    // R10
    set_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_m != '0) |=> ((q & $past(set_m)) == $past(set_m)));

    // R3
    clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_m & ~set_m) != '0) |=> ((q & $past(clr_m & ~set_m)) == '0));

endmodule

// File: rtl/fic_prio.sv
module fic_prio #(
    parameter int LVL_N = 7,
    parameter int LW    = $clog2(LVL_N + 1)
) (
    input  logic [LVL_N-1:0] req,
    output logic [LW-1:0]    top
);

    always_comb begin
        top = '0;
        for (int i = 0; i < LVL_N; i++) begin
            if (req[i]) top = LW'(i + 1);
        end
    end

endmodule

// File: rtl/fic_force_ctl.sv
module fic_force_ctl
    import fic_pkg::*;
#(
    parameter int AW       = 8,
    parameter int DW       = 8,
    parameter int IDX_W    = 6,
    parameter int LVL_N    = 7,
    parameter int IDX_BASE = 32,
    parameter int OFS_FRC  = 8'h1B,
    parameter int OFS_SET  = 8'h1E,
    parameter int OFS_CLR  = 8'h1F,
    localparam int LW      = $clog2(LVL_N + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    output logic             err,
    input  logic             tst_set_en,
    input  logic [IDX_W-1:0] tst_set_idx,
    input  logic             tst_clr_en,
    input  logic [IDX_W-1:0] tst_clr_idx,
    output logic [LVL_N-1:0] frc_req,
    output logic [LW-1:0]    top_lvl
);

    acc_e             acc;
    logic [IDX_W-1:0] bus_idx;
    logic [LVL_N-1:0] bus_set_m, bus_clr_m, hk_set_m, hk_clr_m;
    logic [LVL_N-1:0] set_m, clr_m;
    logic [DW-IDX_W-1:0] unused_rsvd;

    // reserved upper data bits carry no meaning
    assign bus_idx     = wdata[IDX_W-1:0];
    assign unused_rsvd = wdata[DW-1:IDX_W];

    fic_bus_dec #(.AW(AW), .OFS_FRC(OFS_FRC), .OFS_SET(OFS_SET), .OFS_CLR(OFS_CLR))
        u_dec (.addr(addr), .wr_en(wr_en), .rd_en(rd_en), .acc(acc));

    fic_idx_dec #(.LVL_N(LVL_N), .IDX_W(IDX_W), .IDX_BASE(IDX_BASE))
        u_bset (.en(acc == ACC_SET), .idx(bus_idx), .lvl_mask(bus_set_m));
    fic_idx_dec #(.LVL_N(LVL_N), .IDX_W(IDX_W), .IDX_BASE(IDX_BASE))
        u_bclr (.en(acc == ACC_CLR), .idx(bus_idx), .lvl_mask(bus_clr_m));
    fic_idx_dec #(.LVL_N(LVL_N), .IDX_W(IDX_W), .IDX_BASE(IDX_BASE))
        u_hset (.en(tst_set_en), .idx(tst_set_idx), .lvl_mask(hk_set_m));
    fic_idx_dec #(.LVL_N(LVL_N), .IDX_W(IDX_W), .IDX_BASE(IDX_BASE))
        u_hclr (.en(tst_clr_en), .idx(tst_clr_idx), .lvl_mask(hk_clr_m));

    assign set_m = bus_set_m | hk_set_m;
    assign clr_m = bus_clr_m | hk_clr_m;

    fic_force_bank #(.LVL_N(LVL_N))
        u_bank (.clk(clk), .rst_n(rst_n), .set_m(set_m), .clr_m(clr_m), .q(frc_req));

    fic_prio #(.LVL_N(LVL_N), .LW(LW))
        u_prio (.req(frc_req), .top(top_lvl));

    // read path: byte bit j shows level LVL_N-j
    always_comb begin
        rdata = '0;
        err   = 1'b0;
        unique case (acc)
            ACC_READ_FRC: begin
                for (int j = 0; j < LVL_N; j++) rdata[j] = frc_req[LVL_N-1-j];
            end
            ACC_READ_BAD: err = 1'b1;
            default: ;
        endcase
    end

    // R6
    err_with_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (rd_en && !wr_en && (addr == AW'(OFS_SET) || addr == AW'(OFS_CLR))));

    // R6
    err_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (rdata == '0));

    // R8
    top_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (top_lvl == '0) ? (frc_req == '0)
                        : (frc_req[top_lvl-1] && ((frc_req >> top_lvl) == '0)));

    // R2
    bus_set_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == AW'(OFS_SET) && wdata[IDX_W-1:0] == IDX_W'(IDX_BASE))
        |=> (top_lvl == LW'(LVL_N)));

    // R9
    single_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tst_set_en && !tst_clr_en) |=> ($countones(frc_req ^ $past(frc_req)) <= 1));

endmodule

// File: tb/tb_fic_force_ctl.sv
module tb_fic_force_ctl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       err;
    logic       tst_set_en = 1'b0;
    logic [5:0] tst_set_idx = '0;
    logic       tst_clr_en = 1'b0;
    logic [5:0] tst_clr_idx = '0;
    logic [6:0] frc_req;
    logic [2:0] top_lvl;

    int n_chk = 0;
    int n_bad = 0;
    logic [6:0] exp_q = '0;

    always #5 clk = ~clk;

    fic_force_ctl dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .err(err),
        .tst_set_en(tst_set_en), .tst_set_idx(tst_set_idx),
        .tst_clr_en(tst_clr_en), .tst_clr_idx(tst_clr_idx),
        .frc_req(frc_req), .top_lvl(top_lvl)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_top(input logic [6:0] v);
        exp_top = 3'd0;
        for (int i = 0; i < 7; i++) if (v[i]) exp_top = 3'(i + 1);
    endfunction

    function automatic logic [7:0] exp_rb(input logic [6:0] v);
        exp_rb = 8'h00;
        for (int j = 0; j < 7; j++) exp_rb[j] = v[6-j];
    endfunction

    task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [7:0] d, output logic e);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1;
        d = rdata; e = err;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // drive the bank to pattern p through the bus
    task automatic load(input logic [6:0] p);
        for (int k = 0; k < 7; k++)
            bus_wr(p[6-k] ? 8'h1E : 8'h1F, 8'(32 + k));
        exp_q = p;
    endtask

    task automatic check_state(input string req);
        logic [7:0] d;
        logic e;
        chk(frc_req == exp_q, req, frc_req, exp_q);
        chk(top_lvl == exp_top(exp_q), "R8", top_lvl, exp_top(exp_q));
        bus_rd(8'h1B, d, e);
        chk(d == exp_rb(exp_q) && !e, "R7", d, exp_rb(exp_q));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [7:0] d;
        logic e;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(frc_req == 7'h00, "R1", frc_req, 0);
        chk(top_lvl == 3'd0, "R1", top_lvl, 0);
        bus_rd(8'h1B, d, e);
        chk(d == 8'h00, "R1", d, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // set and clear sweeps over every data byte from varied states
        for (int pass = 0; pass < 2; pass++) begin
            for (int b = 0; b < 256; b++) begin
                logic [5:0] ix;
                string tag;
                load(7'((b * 37 + pass * 91) & 127));
                ix = b[5:0];
                bus_wr(pass == 0 ? 8'h1E : 8'h1F, 8'(b));
                if (ix >= 6'd32 && ix <= 6'd38) begin
                    exp_q[6 - (ix - 6'd32)] = (pass == 0);
                    tag = (b[7:6] != 2'b00) ? "R5" : (pass == 0 ? "R2" : "R3");
                end else begin
                    tag = "R4";
                end
                check_state(tag);
                // R9: the rest of the vector is part of the same compare
            end
        end

        // R6 / R7 / R9: read sweep over every address
        load(7'h55);
        for (int a = 0; a < 256; a++) begin
            logic exp_e;
            logic [7:0] exp_d;
            exp_e = (a == 8'h1E || a == 8'h1F);
            exp_d = (a == 8'h1B) ? exp_rb(exp_q) : 8'h00;
            bus_rd(8'(a), d, e);
            chk(e == exp_e, "R6", e, exp_e);
            chk(d == exp_d, "R7", d, exp_d);
        end
        chk(frc_req == exp_q, "R9", frc_req, exp_q);

        // R10: hook set and clear on the same level in one cycle
        for (int k = 0; k < 7; k++) begin
            load(7'h00);
            @(negedge clk);
            tst_set_en = 1'b1; tst_set_idx = 6'(32 + k);
            tst_clr_en = 1'b1; tst_clr_idx = 6'(32 + k);
            @(negedge clk);
            tst_set_en = 1'b0; tst_clr_en = 1'b0;
            exp_q[6-k] = 1'b1;
            chk(frc_req == exp_q, "R10", frc_req, exp_q);
            // hook clear and set on different levels together
            @(negedge clk);
            tst_clr_en = 1'b1; tst_clr_idx = 6'(32 + k);
            tst_set_en = 1'b1; tst_set_idx = 6'(32 + ((k + 3) % 7));
            @(negedge clk);
            tst_set_en = 1'b0; tst_clr_en = 1'b0;
            exp_q[6-k] = 1'b0;
            exp_q[6-((k + 3) % 7)] = 1'b1;
            chk(frc_req == exp_q, "R10", frc_req, exp_q);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule